// File: doc/BRIEF.md
# Hardware Semaphore Register Bank

This block is a bank of hardware lock bits placed on a Wishbone slave port. Several bus masters share it to guard common resources. A master takes a lock by reading that lock's register. The read is an atomic test-and-set:

- If the lock is free, the read sets it and returns 1 in data bit 0.
- If the lock is already held, the read returns 0 and leaves the lock alone.

A caller therefore polls the lock register until it reads 1. It gives the lock back by writing a 1 in bit 0 to the same register.

A separate status word reports every lock that is currently held, one bit per lock. Reading the status word never changes a lock. Every access is acknowledged with a one-cycle ack. The test-and-set is decided in the cycle in which the request is accepted, so a grant cannot be handed out twice.

Top module: `sema_bank`

## Requirements
- R1: After a synchronous active-high reset, all locks are free, ack is low, read data is 0, and the status word reads 0.
- R2: A request (cyc and stb high while ack is low) is acknowledged in the next cycle with an ack that lasts exactly one cycle.
- R3: Lock i (0 to 14) sits at byte offset 4*i. Reading a free lock returns 0x00000001 and marks the lock held in that same access.
- R4: Reading a held lock returns 0x00000000 and leaves every lock unchanged.
- R5: A write releases lock i only when byte-select bit 0 is set and data bit 0 is 1. A write with data bit 0 cleared, or with select bit 0 cleared, changes nothing.
- R6: The status word sits at byte offset 0x40. Bit i is 1 exactly when lock i is held, and the word reflects each acquire and release on the next access. Reading it changes no lock.
- R7: Bits 31 to 1 of every lock read, and bits 31 to 15 of the status word, read as 0. The status word reads 0x7FFF when all locks are held.
- R8: An access to any other word offset (word 15, and words 17 to 63) is acknowledged, returns 0, and changes no lock, whether it is a read or a write.
- R9: When stb is held high across two back-to-back reads of one free lock, only the first read returns 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe, request valid |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W (8) | Byte address; bits 1:0 are ignored |
| wb_dat_i | input | DATA_W (32) | Write data |
| wb_sel_i | input | DATA_W/8 (4) | Byte selects; bit 0 gates a release |
| wb_dat_o | output | DATA_W (32) | Registered read data |
| wb_ack_o | output | 1 | One-cycle acknowledge |

## Verification
A lock bit that is wrongly set or cleared shows up at the ports within one access, in either of two ways. The status word has a wrong bit in it. A lock read returns a grant when it should not, or withholds one it should give. A double grant or a lost release shows up on the very next read of that lock or of the status word. A decode error shows up as a nonzero value from an unmapped word, or as a status change after an access that was meant to have no effect. The bench sweeps every lock and every unmapped word, and after each step compares the status word with a bitmap it keeps itself.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    ACC_HOLE   = 2'd0,
    ACC_LOCK   = 2'd1,
    ACC_STATUS = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sema_decode.sv
module sema_decode
  import sema_pkg::*;
#(
  parameter int NUM_LOCKS   = 15,
  parameter int WORD_W      = 6,
  parameter int STATUS_WORD = 16
) (
  input  logic [WORD_W-1:0]    word,
  output logic [NUM_LOCKS-1:0] lock_hit,
  output acc_kind_e            kind
);
  genvar g;
  generate
    for (g = 0; g < NUM_LOCKS; g++) begin : g_hit
      assign lock_hit[g] = (word == WORD_W'(g));
    end
  endgenerate

  always_comb begin
    if (|lock_hit)                          kind = ACC_LOCK;
    else if (word == WORD_W'(STATUS_WORD))  kind = ACC_STATUS;
    else                                    kind = ACC_HOLE;
  end
endmodule

// File: rtl/sema_lock_array.sv
module sema_lock_array #(
  parameter int NUM_LOCKS = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOCKS-1:0] take,
  input  logic [NUM_LOCKS-1:0] drop,
  output logic [NUM_LOCKS-1:0] held
);
  genvar g;
  generate
    for (g = 0; g < NUM_LOCKS; g++) begin : g_lock
      always_ff @(posedge clk) begin
        if (rst)          held[g] <= 1'b0;
        else if (drop[g]) held[g] <= 1'b0;
        else if (take[g]) held[g] <= 1'b1;
      end

      // R3: a lock only becomes held after a read aimed at it
      p_set_needs_take_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(held[g]) |-> $past(take[g]));
      // R5: a lock only becomes free after a qualifying release write
      p_clear_needs_drop_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(held[g]) |-> $past(drop[g]));
    end
  endgenerate
endmodule

// File: rtl/sema_rdmux.sv
module sema_rdmux
  import sema_pkg::*;
#(
  parameter int NUM_LOCKS = 15,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 we,
  input  acc_kind_e            kind,
  input  logic [NUM_LOCKS-1:0] lock_hit,
  input  logic [NUM_LOCKS-1:0] held,
  output logic                 ack,
  output logic [DATA_W-1:0]    dat
);
  logic              fire;
  logic              grant;
  logic [DATA_W-1:0] rd_val;

  assign fire  = req & ~ack;
  assign grant = |(lock_hit & ~held);

  always_comb begin
    rd_val = '0;
    unique case (kind)
      ACC_LOCK:   rd_val[0] = grant;
      ACC_STATUS: rd_val[NUM_LOCKS-1:0] = held;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      dat <= '0;
    end else begin
      ack <= fire;
      dat <= (fire && !we) ? rd_val : '0;
    end
  end

  // R2: the ack is a single-cycle pulse
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R2: an accepted request is acknowledged in the next cycle
  p_ack_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> ack);
endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int NUM_LOCKS   = 15,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int STATUS_WORD = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [ADDR_W-1:0]   wb_adr_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  input  logic [DATA_W/8-1:0] wb_sel_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int SEL_W  = DATA_W / 8;

  logic                 req;
  logic                 fire;
  logic                 rel_ok;
  logic [NUM_LOCKS-1:0] lock_hit;
  logic [NUM_LOCKS-1:0] take;
  logic [NUM_LOCKS-1:0] drop;
  logic [NUM_LOCKS-1:0] held;
  acc_kind_e            kind;
  logic                 unused_bits;

  assign unused_bits = ^{wb_adr_i[1:0], wb_sel_i[SEL_W-1:1], wb_dat_i[DATA_W-1:1]};

  assign req    = wb_cyc_i & wb_stb_i;
  assign fire   = req & ~wb_ack_o;
  assign rel_ok = wb_we_i & wb_sel_i[0] & wb_dat_i[0];
  assign take   = lock_hit & {NUM_LOCKS{fire & ~wb_we_i}};
  assign drop   = lock_hit & {NUM_LOCKS{fire & rel_ok}};

  sema_decode #(
    .NUM_LOCKS  (NUM_LOCKS),
    .WORD_W     (WORD_W),
    .STATUS_WORD(STATUS_WORD)
  ) u_decode (
    .word    (wb_adr_i[ADDR_W-1:2]),
    .lock_hit(lock_hit),
    .kind    (kind)
  );

  sema_lock_array #(
    .NUM_LOCKS(NUM_LOCKS)
  ) u_locks (
    .clk (clk),
    .rst (rst),
    .take(take),
    .drop(drop),
    .held(held)
  );

  sema_rdmux #(
    .NUM_LOCKS(NUM_LOCKS),
    .DATA_W   (DATA_W)
  ) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (wb_we_i),
    .kind    (kind),
    .lock_hit(lock_hit),
    .held    (held),
    .ack     (wb_ack_o),
    .dat     (wb_dat_o)
  );

  // R1: the cycle after reset leaves every lock free and the port idle
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (held == '0 && !wb_ack_o && wb_dat_o == '0));
  // R6: reading the status word leaves the locks as they were
  p_status_read_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && !wb_we_i && kind == ACC_STATUS) |=> held == $past(held));
  // R8: an unmapped access leaves the locks as they were
  p_hole_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == ACC_HOLE) |=> held == $past(held));
  // R8: an unmapped access returns zero
  p_hole_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == ACC_HOLE) |=> wb_dat_o == '0);
  // R7: a lock read drives nothing above bit 0
  p_lock_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == ACC_LOCK) |=> wb_dat_o[DATA_W-1:1] == '0);
  // R4: a lock read that finds the lock held grants nothing
  p_no_regrant_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && !wb_we_i && kind == ACC_LOCK && (lock_hit & held) != '0) |=> !wb_dat_o[0]);
endmodule

// File: tb/tb_sema_bank.sv
module tb_sema_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [3:0]  sel = '0;
  logic [31:0] rdat;
  logic        ack;

  int total = 0;
  int bad   = 0;
  logic [14:0] model = '0;
  logic [31:0] got;

  localparam logic [7:0] STATUS_ADR = 8'h40;

  always #10 clk = ~clk;

  sema_bank dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel),
    .wb_dat_o(rdat), .wb_ack_o(ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] r);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = s;
    @(negedge clk);
    chk("R2 ack", {31'd0, ack}, 32'd1);
    r = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R2 ack pulse", {31'd0, ack}, 32'd0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    xfer(1'b0, a, 32'd0, 4'hF, r);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] dummy;
    xfer(1'b1, a, d, s, dummy);
  endtask

  task automatic chk_status(input string req);
    logic [31:0] r;
    rd(STATUS_ADR, r);
    chk(req, r, {17'd0, model});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack", {31'd0, ack}, 32'd0);
    chk("R1 data", rdat, 32'd0);
    chk_status("R1 status");

    // one lock at a time
    for (int i = 0; i < 15; i++) begin
      rd(8'(4*i), got);
      chk("R3 grant", got, 32'd1);
      model[i] = 1'b1;
      chk_status("R6 after acquire");
      rd(8'(4*i), got);
      chk("R4 held read", got, 32'd0);
      chk_status("R4 unchanged");
      wr(8'(4*i), 32'hFFFF_FFFE, 4'hF);
      chk_status("R5 data0 clear");
      wr(8'(4*i), 32'd1, 4'hE);
      chk_status("R5 sel0 clear");
      wr(8'(4*i), 32'd1, 4'h1);
      model[i] = 1'b0;
      chk_status("R5 release");
    end

    // all locks
    for (int i = 0; i < 15; i++) begin
      rd(8'(4*i), got);
      chk("R3 grant all", got, 32'd1);
      model[i] = 1'b1;
      chk_status("R6 accumulate");
    end
    rd(STATUS_ADR, got);
    chk("R7 full", got, 32'h0000_7FFF);
    for (int i = 14; i >= 0; i--) begin
      wr(8'(4*i), 32'd1, 4'hF);
      model[i] = 1'b0;
      chk_status("R6 release order");
    end

    // unmapped words with a pattern held
    for (int i = 0; i < 15; i += 2) begin
      rd(8'(4*i), got);
      model[i] = 1'b1;
    end
    for (int w = 15; w < 64; w++) begin
      if (w != 16) begin
        rd(8'(4*w), got);
        chk("R8 read zero", got, 32'd0);
        wr(8'(4*w), 32'hFFFF_FFFF, 4'hF);
        chk_status("R8 no change");
      end
    end
    for (int i = 0; i < 15; i++) begin
      wr(8'(4*i), 32'd1, 4'hF);
      model[i] = 1'b0;
    end
    chk_status("R5 all released");

    // back-to-back reads of one free lock
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 8'd12; sel = 4'hF;
    @(negedge clk);
    chk("R9 first ack", {31'd0, ack}, 32'd1);
    chk("R9 first grant", rdat, 32'd1);
    @(negedge clk);
    chk("R9 gap", {31'd0, ack}, 32'd0);
    @(negedge clk);
    chk("R9 second ack", {31'd0, ack}, 32'd1);
    chk("R9 second denied", rdat, 32'd0);
    cyc = 1'b0; stb = 1'b0;
    model[3] = 1'b1;
    chk_status("R9 status");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule